// File: doc/BRIEF.md
# Multi-CPU level interrupt aggregator

This block gathers a parameterised set of active-high, level-sensitive peripheral interrupt lines and drives one interrupt request per CPU. Each line passes through a two-flop synchroniser. After that it is visible to every CPU. Each CPU owns a private bank of registers. The bank holds one enable word for every 32 lines and one status word for every 32 lines. A CPU is interrupted when any line it has enabled is high. A line is sent to one CPU, to several or to none purely by the enable bits in each bank.

The block has no priority logic, no vector generation, no queue, no edge capture and no polarity control. A CPU finds out which lines are pending by reading all the status words in its own bank. Enables change only through plain full-word writes. Registers are accessed over a simple word-wide bus. A read is issued with a one-cycle strobe, and its data appears on the next clock. Bytes are presented in the host's native order, with no swap option.

Top module: `irq_router_top`

## Requirements
- R1: `NUM_LINES` is 32, 64 or 128, and `W = NUM_LINES/32`. CPU c owns the byte window starting at c·8W, and that window is 8W bytes long (32 bytes for 128 lines). Inside the window, byte offset 4k holds enable word k and byte offset 4W+4k holds status word k, for k < W. Bit b of word k stands for line 32k+b. Address bits [1:0] are ignored.
- R2: After reset every enable bit is 0 and every `irq_cpu_o` bit is 0. Status reads return 0 even while lines are high.
- R3: A write to an enable word replaces the whole 32-bit value. A read issued with `bus_rd_en` in one cycle shows its data on `bus_rdata` after the next rising edge. `bus_rdata` holds its value while no read is issued.
- R4: A status word reads as the synchronised line levels ANDed with that CPU's enable word. Writes to status words change no enable and no status.
- R5: A write to one CPU's bank leaves every other CPU's enables, status words and `irq_cpu_o` bit unchanged.
- R6: A raw line change on an enabled line reaches `irq_cpu_o` on the third rising edge after it is applied: two synchroniser stages, then the output register. This holds for both assertion and deassertion.
- R7: When the synchronised line is already high, `irq_cpu_o` changes on the first rising edge after the edge that writes the enable. A write that enables the line asserts the output, and a write that disables the last active source deasserts it.
- R8: Only a high line level requests an interrupt. Low lines never do, whatever the enables are set to.
- R9: A read and a write of the same enable word in the same cycle return the value held before the write. A read of that word in a later cycle returns the new value.
- R10: Addresses whose CPU field is NUM_CPUS or greater read as 0. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines_i | input | NUM_LINES | Raw peripheral interrupt levels, active high |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address (CPU field, word index, 2 ignored bits) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read strobe |
| irq_cpu_o | output | NUM_CPUS | Registered interrupt request, one bit per CPU |

## Verification
Two pairs of events can fall in the same cycle, and each pair is provoked on purpose.

- **Read and write of one enable word.** The bench raises the read strobe and the write strobe together on the same enable address. It expects `bus_rdata` to carry the old model value, and a read one cycle later to carry the new one.
- **Enable write and interrupt output.** The bench writes an enable word while the synchronised line is held high. It judges `irq_cpu_o` on the edge after the write, checking both directions.

An exhaustive sweep then covers every line on every CPU of a 64-line, 3-CPU build. Each status word and every interrupt output is compared with a model that ANDs the line vector with the bench's own enable copy.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  // Width of one register word on the bus.
  localparam int WORD_W = 32;

  // Number of enable (or status) words needed for a given line count.
  function automatic int words_for(input int lines);
    return lines / WORD_W;
  endfunction

  // Number of index bits that cover enable words plus status words.
  function automatic int idx_bits_for(input int lines);
    return $clog2(2 * words_for(lines));
  endfunction

  typedef logic [WORD_W-1:0] word_t;

endpackage

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] lvl_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      lvl_q  <= '0;
    end else begin
      meta_q <= raw_i;
      lvl_q  <= meta_q;
    end
  end

  assign lvl_o = lvl_q;

  // Count edges since reset, so the delay check only looks at post-reset history.
  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R6: the synchronised level equals the raw input two edges earlier.
  assert_sync_two_stage_R6: assert property (@(posedge clk) disable iff (rst)
    (warm_q >= 2'd2) |-> (lvl_q == $past(raw_i, 2)));

endmodule

// File: rtl/irq_cpu_bank.sv
module irq_cpu_bank
  import irq_router_pkg::*;
#(
  parameter int NWORDS = 4,
  parameter int IDX_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_sel,
  input  logic [IDX_W-1:0]         wr_idx,
  input  word_t                    wr_data,
  input  logic [NWORDS*WORD_W-1:0] lvl_i,
  output logic [NWORDS*WORD_W-1:0] en_o,
  output logic [NWORDS*WORD_W-1:0] status_o,
  output logic                     irq_o
);

  localparam int LINES = NWORDS * WORD_W;

  logic [LINES-1:0] en_q;
  logic [LINES-1:0] masked;
  logic             irq_q;

  // One enable word per group of 32 lines; status indices never match here.
  for (genvar k = 0; k < NWORDS; k++) begin : g_en_word
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[k*WORD_W +: WORD_W] <= '0;
      end else if (wr_sel && (wr_idx == IDX_W'(k))) begin
        en_q[k*WORD_W +: WORD_W] <= wr_data;
      end
    end
  end

  assign masked = lvl_i & en_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |masked;
  end

  assign en_o     = en_q;
  assign status_o = masked;
  assign irq_o    = irq_q;

  // R5: without a write aimed at this bank, its enables do not move.
  assert_en_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_sel) |-> $stable(en_q));

  // R4: a write aimed at a status word leaves the enables untouched.
  assert_status_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_sel) && $past(wr_idx[IDX_W-1])) |-> $stable(en_q));

  // R7: a raised request implies some enable bit was set one edge earlier.
  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(en_q) != '0));

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_router_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NWORDS   = 4,
  parameter int IDX_W    = 3,
  parameter int CPU_W    = 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rd_en,
  input  logic [CPU_W-1:0]                  rd_cpu,
  input  logic [IDX_W-1:0]                  rd_idx,
  input  logic [NUM_CPUS*NWORDS*WORD_W-1:0] en_all,
  input  logic [NUM_CPUS*NWORDS*WORD_W-1:0] st_all,
  output word_t                             rdata_o
);

  localparam int LINES = NWORDS * WORD_W;

  word_t word_d;
  word_t rdata_q;

  always_comb begin
    int cpu_n;
    int idx_n;
    int base;
    word_d = '0;
    cpu_n  = int'(rd_cpu);
    idx_n  = int'(rd_idx);
    base   = 0;
    if (cpu_n < NUM_CPUS) begin
      base = cpu_n * LINES;
      if (idx_n < NWORDS) word_d = en_all[base + idx_n*WORD_W +: WORD_W];
      else                word_d = st_all[base + (idx_n - NWORDS)*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= word_d;
  end

  assign rdata_o = rdata_q;

  // R3: read data holds while no read is issued.
  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rdata_q));

  // R10: reads of an unmapped CPU field return zero.
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && ({1'b0, $past(rd_cpu)} >= (CPU_W+1)'(NUM_CPUS))) |-> (rdata_q == '0));

endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES = 128,
  parameter int NUM_CPUS  = 2,
  parameter int CPU_W     = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  parameter int ADDR_W    = CPU_W + idx_bits_for(NUM_LINES) + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic                 bus_wr_en,
  input  logic                 bus_rd_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic [NUM_CPUS-1:0]  irq_cpu_o
);

  localparam int NWORDS = words_for(NUM_LINES);
  localparam int IDX_W  = idx_bits_for(NUM_LINES);

  if (!(NUM_LINES == 32 || NUM_LINES == 64 || NUM_LINES == 128)) begin : g_bad_lines
    $error("NUM_LINES must be 32, 64 or 128");
  end

  logic [NUM_LINES-1:0]          lvl;
  logic [IDX_W-1:0]              word_idx;
  logic [CPU_W-1:0]              cpu_sel;
  logic [NUM_CPUS*NUM_LINES-1:0] en_all;
  logic [NUM_CPUS*NUM_LINES-1:0] st_all;
  logic                          unused_byte_lane;

  assign word_idx         = bus_addr[2 +: IDX_W];
  assign cpu_sel          = bus_addr[2 + IDX_W +: CPU_W];
  assign unused_byte_lane = ^bus_addr[1:0];

  irq_level_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .raw_i (irq_lines_i),
    .lvl_o (lvl)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic bank_wr;
    assign bank_wr = bus_wr_en && (int'(cpu_sel) == c);

    irq_cpu_bank #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wr_sel   (bank_wr),
      .wr_idx   (word_idx),
      .wr_data  (bus_wdata),
      .lvl_i    (lvl),
      .en_o     (en_all[c*NUM_LINES +: NUM_LINES]),
      .status_o (st_all[c*NUM_LINES +: NUM_LINES]),
      .irq_o    (irq_cpu_o[c])
    );

    // R8: a request only follows some synchronised line being high.
    assert_irq_from_high_level_R8: assert property (@(posedge clk) disable iff (rst)
      irq_cpu_o[c] |-> ($past(lvl) != '0));
  end

  irq_read_port #(
    .NUM_CPUS (NUM_CPUS),
    .NWORDS   (NWORDS),
    .IDX_W    (IDX_W),
    .CPU_W    (CPU_W)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (bus_rd_en),
    .rd_cpu  (cpu_sel),
    .rd_idx  (word_idx),
    .en_all  (en_all),
    .st_all  (st_all),
    .rdata_o (bus_rdata)
  );

  // R2: the first cycle out of reset has every request low.
  assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (irq_cpu_o == '0));

endmodule

// File: tb/test_irq_router_top.sv
module test_irq_router_top;

  localparam int LINES = 64;
  localparam int CPUS  = 3;
  localparam int AW    = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [LINES-1:0] lines = '0;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [CPUS-1:0] irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_en [CPUS][2];

  always #10 clk = ~clk;

  irq_router_top #(.NUM_LINES(LINES), .NUM_CPUS(CPUS)) i_irq_router_top (
    .clk         (clk),
    .rst         (rst),
    .irq_lines_i (lines),
    .bus_wr_en   (wr_en),
    .bus_rd_en   (rd_en),
    .bus_addr    (addr),
    .bus_wdata   (wdata),
    .bus_rdata   (rdata),
    .irq_cpu_o   (irq)
  );

  function automatic logic [AW-1:0] en_addr(input int c, input int k);
    return AW'(c*16 + k*4);
  endfunction

  function automatic logic [AW-1:0] st_addr(input int c, input int k);
    return AW'(c*16 + 8 + k*4);
  endfunction

  function automatic logic [31:0] exp_st(input int c, input int k);
    return lines[k*32 +: 32] & m_en[c][k];
  endfunction

  function automatic logic [CPUS-1:0] exp_irq();
    logic [CPUS-1:0] r;
    for (int c = 0; c < CPUS; c++) r[c] = |(lines & {m_en[c][1], m_en[c][0]});
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (int'(a[5:4]) < CPUS && a[3] == 1'b0) m_en[int'(a[5:4])][int'(a[2])] = d;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic clear_all();
    for (int c = 0; c < CPUS; c++)
      for (int k = 0; k < 2; k++) bus_wr(en_addr(c, k), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < CPUS; c++) begin m_en[c][0] = '0; m_en[c][1] = '0; end
    wait_n(5);
    rst = 1'b0;
    wait_n(1);
    chk("R2 irq after reset", 64'(irq), 64'(0));

    // R2/R8: all lines high but nothing enabled.
    lines = '1;
    wait_n(4);
    chk("R2 irq with lines high, no enable", 64'(irq), 64'(0));
    for (int c = 0; c < CPUS; c++)
      for (int k = 0; k < 2; k++) begin
        bus_rd(st_addr(c, k), d);
        chk("R2 status after reset", 64'(d), 64'(0));
        bus_rd(en_addr(c, k), d);
        chk("R2 enable after reset", 64'(d), 64'(0));
      end
    lines = '0;
    wait_n(3);

    // R3: full-word enable writes read back per CPU and word.
    for (int c = 0; c < CPUS; c++)
      for (int k = 0; k < 2; k++) bus_wr(en_addr(c, k), 32'hA5C3_0000 ^ 32'(c*16 + k*4 + 1));
    for (int c = 0; c < CPUS; c++)
      for (int k = 0; k < 2; k++) begin
        bus_rd(en_addr(c, k), d);
        chk("R3 enable readback", 64'(d), 64'(m_en[c][k]));
      end
    bus_wr(en_addr(1, 0), 32'h0000_00F0);
    bus_rd(en_addr(1, 0), d);
    chk("R3 full word replace", 64'(d), 64'(32'h0000_00F0));
    wait_n(2);
    chk("R3 rdata held without read", 64'(rdata), 64'(32'h0000_00F0));
    clear_all();

    // R8: all enabled, lines low -> no interrupt.
    for (int c = 0; c < CPUS; c++)
      for (int k = 0; k < 2; k++) bus_wr(en_addr(c, k), 32'hFFFF_FFFF);
    wait_n(4);
    chk("R8 low lines no irq", 64'(irq), 64'(0));
    clear_all();

    // R1/R4/R5: exhaustive sweep over every line on every CPU.
    for (int c = 0; c < CPUS; c++)
      for (int n = 0; n < LINES; n++) begin
        bus_wr(en_addr(c, n/32), 32'h1 << (n % 32));
        lines[n] = 1'b1;
        wait_n(3);
        chk("R1 sweep irq routing", 64'(irq), 64'(exp_irq()));
        bus_rd(st_addr(c, n/32), d);
        chk("R4 sweep status bit", 64'(d), 64'(exp_st(c, n/32)));
        bus_rd(st_addr(c, 1 - n/32), d);
        chk("R1 sweep other status word", 64'(d), 64'(0));
        bus_rd(st_addr((c + 1) % CPUS, n/32), d);
        chk("R5 sweep other cpu status", 64'(d), 64'(0));
        lines[n] = 1'b0;
        bus_wr(en_addr(c, n/32), 32'h0);
        wait_n(2);
      end

    // R6: latency from raw line to output, rise and fall.
    bus_wr(en_addr(0, 0), 32'h20);
    lines[5] = 1'b1;
    wait_n(1); chk("R6 rise edge1", 64'(irq[0]), 64'(0));
    wait_n(1); chk("R6 rise edge2", 64'(irq[0]), 64'(0));
    wait_n(1); chk("R6 rise edge3", 64'(irq[0]), 64'(1));
    lines[5] = 1'b0;
    wait_n(1); chk("R6 fall edge1", 64'(irq[0]), 64'(1));
    wait_n(1); chk("R6 fall edge2", 64'(irq[0]), 64'(1));
    wait_n(1); chk("R6 fall edge3", 64'(irq[0]), 64'(0));

    // R7: output follows enable writes one edge later.
    lines[5] = 1'b1;
    wait_n(3);
    chk("R7 irq on before disable", 64'(irq[0]), 64'(1));
    bus_wr(en_addr(0, 0), 32'h0);
    chk("R7 irq at write edge", 64'(irq[0]), 64'(1));
    wait_n(1);
    chk("R7 irq drops after disable", 64'(irq[0]), 64'(0));
    bus_wr(en_addr(0, 0), 32'h20);
    chk("R7 irq still low at write edge", 64'(irq[0]), 64'(0));
    wait_n(1);
    chk("R7 irq rises after enable", 64'(irq[0]), 64'(1));

    // R4: writes to status words are ignored.
    bus_wr(en_addr(1, 0), 32'h0000_0021);
    wait_n(1);
    wr_en = 1'b1; addr = st_addr(1, 0); wdata = 32'hFFFF_FFFF;
    wait_n(1);
    wr_en = 1'b0;
    bus_rd(en_addr(1, 0), d);
    chk("R4 status write leaves enable", 64'(d), 64'(32'h21));
    bus_rd(st_addr(1, 0), d);
    chk("R4 status write leaves status", 64'(d), 64'(exp_st(1, 0)));
    chk("R4 status write leaves irq", 64'(irq), 64'(exp_irq()));

    // R5: one CPU enabling everything does not reach the others.
    clear_all();
    lines = '1;
    bus_wr(en_addr(0, 0), 32'hFFFF_FFFF);
    bus_wr(en_addr(0, 1), 32'hFFFF_FFFF);
    wait_n(3);
    chk("R5 only cpu0 interrupted", 64'(irq), 64'(3'b001));
    bus_rd(st_addr(2, 1), d);
    chk("R5 cpu2 status clear", 64'(d), 64'(0));
    bus_rd(en_addr(1, 1), d);
    chk("R5 cpu1 enable untouched", 64'(d), 64'(0));

    // R9: same-cycle read and write of one enable word.
    bus_wr(en_addr(2, 1), 32'h1234_5678);
    wr_en = 1'b1; rd_en = 1'b1; addr = en_addr(2, 1); wdata = 32'h0BAD_F00D;
    wait_n(1);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R9 same-cycle read sees old", 64'(rdata), 64'(32'h1234_5678));
    m_en[2][1] = 32'h0BAD_F00D;
    bus_rd(en_addr(2, 1), d);
    chk("R9 later read sees new", 64'(d), 64'(32'h0BAD_F00D));
    wait_n(2);
    chk("R9 irq after collision", 64'(irq), 64'(exp_irq()));

    // R10: unmapped CPU field.
    bus_wr(6'd48, 32'hFFFF_FFFF);
    bus_rd(6'd48, d);
    chk("R10 unmapped read zero", 64'(d), 64'(0));
    bus_rd(6'd60, d);
    chk("R10 unmapped status read zero", 64'(d), 64'(0));
    bus_rd(en_addr(1, 0), d);
    chk("R10 unmapped write harmless", 64'(d), 64'(m_en[1][0]));
    chk("R10 irq unchanged", 64'(irq), 64'(exp_irq()));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule